// File: doc/BRIEF.md
# Shared Line Bus with Per-Core Line Buffers

Eight cores reach one line-wide memory bank over a single shared bus. A line is eight 32-bit words, 256 bits in all. The bank has one port, and the bus carries one transaction per cycle, so the whole group shares 256 bits of bandwidth per cycle. To keep cores off that port, each core has a buffer that holds one line: the line it fetched most recently.

A load that finds its line in the core's own buffer completes locally in the cycle it is presented. A load that misses asks for the bus. When the bus is granted, the whole line is read from the bank and placed in the buffer, and the requested word goes back to the core. Stores always use the bus. Each store carries the line number, a one-hot word select and the data, and writes through to the bank. Every buffer watches the bus. A buffer held by another core drops its copy when a store hits its line, and the storing core's own copy takes the new word. A round-robin arbiter decides who gets the bus.

A core raises its request with its operands and holds them until `core_done` is high in a sampled cycle. It lowers the request after that clock edge.

Top module: `shared_line_bus`

## Requirements
- R1: After reset every line buffer is empty and every bank word reads as zero, and no `core_done` bit is high while no request is present.
- R2: A load that misses is granted in some cycle G. `core_done` is high in cycle G+1, carrying the bank word at bits [w*32 +: 32] of the line, where w is the word index. The line is kept in that core's buffer.
- R3: A load whose line is held in the core's own buffer completes in the cycle it is presented, without a bus transaction. No `core_done` bit is ever high without its request.
- R4: A store completes in the cycle it is granted, and the bank holds the new word from the next cycle on.
- R5: When a core stores to the line its own buffer holds, that buffer takes the new word, so a later load by that core hits and returns it.
- R6: When a core stores to a line that another core's buffer holds, that buffer is invalidated. The other core's next load of the line misses and returns the new word.
- R7: The arbiter is round-robin. Search starts at the core after the last one granted, and from reset it starts at core 0. With all eight cores missing together, they are served in the order 0, 1, …, 7, one per cycle.
- R8: The bus grants at most one core per cycle. A core waiting for its line to return does not request again.
- R9: A buffer hit is withheld in a cycle in which another core's store to the same line is on the bus. The load is completed later, with the new data.
- R10: A store to a line in the cycle that line returns to a buffer is merged into the buffer copy, so the copy is never stale.
- R11: A store changes only the word its one-hot select names, both in the bank and in buffers that hold the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 8 | Request valid, one bit per core |
| core_we | input | 8 | 1 = store, 0 = load, one bit per core |
| core_line | input | 48 | Line number, 6 bits per core (core i at [i*6 +: 6]) |
| core_word | input | 24 | Word index within the line, 3 bits per core |
| core_wdata | input | 256 | Store data, 32 bits per core |
| core_done | output | 8 | Request completes this cycle, one bit per core |
| core_rdata | output | 256 | Load data, 32 bits per core, valid with `core_done` |

## Verification
Buffer hits and stores granted on an idle bus are due in the same cycle the request appears. A miss is due exactly one cycle after its grant, because the bank read is registered. The bench drives inputs 2 ns after a rising edge and samples 2 ns later, so it counts latency in whole cycles and compares it with 0 or 1 as each requirement states. The contention, blocking and merge scenarios check the expected `core_done` vector cycle by cycle. They lower a request only after the edge that completed it.

// File: rtl/slb_pkg.sv
package slb_pkg;
    typedef enum logic [0:0] {
        BUS_READ  = 1'b0,
        BUS_WRITE = 1'b1
    } bus_op_e;
endpackage

// File: rtl/slb_rr_arbiter.sv
module slb_rr_arbiter #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_any
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        logic [IW:0] pos;
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int off = 0; off < N; off++) begin
            pos = {1'b0, st_q.ptr} + (IW+1)'(off);
            if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
            if (!gnt_any && req[pos[IW-1:0]]) begin
                gnt_any            = 1'b1;
                gnt_idx            = pos[IW-1:0];
                gnt[pos[IW-1:0]]   = 1'b1;
            end
        end
        if (gnt_any) begin
            st_d.ptr = (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/slb_line_buf.sv
module slb_line_buf #(
    parameter int LA    = 6,
    parameter int WPL   = 8,
    parameter int WW    = 32,
    parameter int IW    = 3,
    parameter int MY_ID = 0,
    localparam int WIW  = $clog2(WPL),
    localparam int LW   = WPL * WW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [LA-1:0]  req_line,
    input  logic [WIW-1:0] req_word,
    input  logic           snp_valid,
    input  logic           snp_write,
    input  logic [IW-1:0]  snp_src,
    input  logic [LA-1:0]  snp_line,
    input  logic [WPL-1:0] snp_wen,
    input  logic [WW-1:0]  snp_wdata,
    input  logic           fill_en,
    input  logic [LA-1:0]  fill_line,
    input  logic [LW-1:0]  fill_data,
    output logic           hit_raw,
    output logic           hit_ok,
    output logic [WW-1:0]  hit_data
);
    typedef struct packed {
        logic          valid;
        logic [LA-1:0] tag;
        logic [LW-1:0] data;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        logic snp_wr;
        logic from_other;
        logic [LW-1:0] merged;
        st_d       = st_q;
        snp_wr     = snp_valid && snp_write;
        from_other = (snp_src != IW'(MY_ID));

        hit_raw  = st_q.valid && (st_q.tag == req_line);
        hit_ok   = hit_raw && !(snp_wr && from_other && (snp_line == req_line));
        hit_data = st_q.data[req_word*WW +: WW];

        if (snp_wr && st_q.valid && (st_q.tag == snp_line)) begin
            if (from_other) begin
                st_d.valid = 1'b0;
            end else begin
                for (int w = 0; w < WPL; w++) begin
                    if (snp_wen[w]) st_d.data[w*WW +: WW] = snp_wdata;
                end
            end
        end

        merged = fill_data;
        if (snp_wr && (snp_line == fill_line)) begin
            for (int w = 0; w < WPL; w++) begin
                if (snp_wen[w]) merged[w*WW +: WW] = snp_wdata;
            end
        end
        if (fill_en) begin
            st_d.valid = 1'b1;
            st_d.tag   = fill_line;
            st_d.data  = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/slb_bank.sv
module slb_bank #(
    parameter int LA   = 6,
    parameter int WPL  = 8,
    parameter int WW   = 32,
    localparam int LW    = WPL * WW,
    localparam int LINES = 1 << LA
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           we,
    input  logic [LA-1:0]  line,
    input  logic [WPL-1:0] wen,
    input  logic [WW-1:0]  wdata,
    output logic [LW-1:0]  rdata
);
    typedef struct packed {
        logic [LINES-1:0][LW-1:0] mem;
        logic [LW-1:0]            rd;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en && we) begin
            for (int w = 0; w < WPL; w++) begin
                if (wen[w]) st_d.mem[line][w*WW +: WW] = wdata;
            end
        end else if (en) begin
            st_d.rd = st_q.mem[line];
        end
    end

    assign rdata = st_q.rd;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/shared_line_bus.sv
module shared_line_bus #(
    parameter int CORES      = 8,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int LINE_AW    = 6,
    localparam int CIW    = $clog2(CORES),
    localparam int WIW    = $clog2(LINE_WORDS),
    localparam int LINE_W = LINE_WORDS * WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CORES-1:0]         core_req,
    input  logic [CORES-1:0]         core_we,
    input  logic [CORES*LINE_AW-1:0] core_line,
    input  logic [CORES*WIW-1:0]     core_word,
    input  logic [CORES*WORD_W-1:0]  core_wdata,
    output logic [CORES-1:0]         core_done,
    output logic [CORES*WORD_W-1:0]  core_rdata
);
    import slb_pkg::*;

    typedef struct packed {
        logic               fill_vld;
        logic [CIW-1:0]     fill_core;
        logic [LINE_AW-1:0] fill_line;
        logic [WIW-1:0]     fill_word;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CORES-1:0]      bus_req;
    logic [CORES-1:0]      gnt;
    logic [CIW-1:0]        gnt_idx;
    logic                  gnt_any;
    logic                  bus_valid;
    logic                  bus_write;
    bus_op_e               bus_op;
    logic [LINE_AW-1:0]    bus_line;
    logic [WIW-1:0]        bus_word;
    logic [LINE_WORDS-1:0] bus_wen;
    logic [WORD_W-1:0]     bus_wdata;
    logic [LINE_W-1:0]     bank_rdata;
    logic [CORES-1:0]      fill_en;
    logic [CORES-1:0]      hit_raw;
    logic [CORES-1:0]      hit_ok;
    logic [WORD_W-1:0]     hit_data [CORES];

    always_comb begin
        for (int i = 0; i < CORES; i++) begin
            fill_en[i] = st_q.fill_vld && (st_q.fill_core == CIW'(i));
            bus_req[i] = core_req[i] && (core_we[i] || !hit_raw[i]) && !fill_en[i];
        end
    end

    slb_rr_arbiter #(.N(CORES), .IW(CIW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    always_comb begin
        bus_valid = gnt_any;
        bus_write = core_we[gnt_idx];
        bus_op    = bus_write ? BUS_WRITE : BUS_READ;
        bus_line  = core_line[gnt_idx*LINE_AW +: LINE_AW];
        bus_word  = core_word[gnt_idx*WIW +: WIW];
        bus_wdata = core_wdata[gnt_idx*WORD_W +: WORD_W];
        bus_wen   = '0;
        if (bus_op == BUS_WRITE) bus_wen[bus_word] = 1'b1;
    end

    slb_bank #(.LA(LINE_AW), .WPL(LINE_WORDS), .WW(WORD_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bus_valid),
        .we    (bus_valid && (bus_op == BUS_WRITE)),
        .line  (bus_line),
        .wen   (bus_wen),
        .wdata (bus_wdata),
        .rdata (bank_rdata)
    );

    for (genvar g = 0; g < CORES; g++) begin : g_buf
        slb_line_buf #(
            .LA(LINE_AW), .WPL(LINE_WORDS), .WW(WORD_W), .IW(CIW), .MY_ID(g)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_line  (core_line[g*LINE_AW +: LINE_AW]),
            .req_word  (core_word[g*WIW +: WIW]),
            .snp_valid (bus_valid),
            .snp_write (bus_write),
            .snp_src   (gnt_idx),
            .snp_line  (bus_line),
            .snp_wen   (bus_wen),
            .snp_wdata (bus_wdata),
            .fill_en   (fill_en[g]),
            .fill_line (st_q.fill_line),
            .fill_data (bank_rdata),
            .hit_raw   (hit_raw[g]),
            .hit_ok    (hit_ok[g]),
            .hit_data  (hit_data[g])
        );
    end

    always_comb begin
        st_d           = st_q;
        st_d.fill_vld  = bus_valid && (bus_op == BUS_READ);
        st_d.fill_core = gnt_idx;
        st_d.fill_line = bus_line;
        st_d.fill_word = bus_word;

        core_done  = '0;
        core_rdata = '0;
        for (int i = 0; i < CORES; i++) begin
            if (fill_en[i]) begin
                core_done[i] = 1'b1;
                core_rdata[i*WORD_W +: WORD_W] = bank_rdata[st_q.fill_word*WORD_W +: WORD_W];
            end else if (gnt[i] && core_we[i]) begin
                core_done[i] = 1'b1;
            end else if (core_req[i] && !core_we[i] && hit_ok[i]) begin
                core_done[i] = 1'b1;
                core_rdata[i*WORD_W +: WORD_W] = hit_data[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int C  = 8,
    parameter int LA = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [C-1:0]  core_req,
    input logic [C-1:0]  core_we,
    input logic [C*LA-1:0] core_line,
    input logic [C-1:0]  core_done,
    input logic [C-1:0]  gnt,
    input logic [C-1:0]  fill_en,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [LA-1:0] bus_line
);
    p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    for (genvar i = 0; i < C; i++) begin : g_core
        p_done_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
            core_done[i] |-> core_req[i]);

        p_miss_returns_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && bus_valid && !bus_write) |=> core_done[i]);

        p_store_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[i] && bus_valid && bus_write) |-> core_done[i]);

        p_no_stale_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_write && !gnt[i] && core_req[i] && !core_we[i]
             && !fill_en[i] && (core_line[i*LA +: LA] == bus_line)) |-> !core_done[i]);

        p_waiting_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fill_en[i] |-> !gnt[i]);
    end
endmodule

bind shared_line_bus slb_checker #(.C(CORES), .LA(LINE_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_req  (core_req),
    .core_we   (core_we),
    .core_line (core_line),
    .core_done (core_done),
    .gnt       (gnt),
    .fill_en   (fill_en),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_line  (bus_line)
);

// File: tb/shared_line_bus_test.sv
`timescale 1ns/1ps
module shared_line_bus_test;
    localparam int C  = 8;
    localparam int WW = 32;
    localparam int LA = 6;
    localparam int WI = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [C-1:0] req = '0;
    logic [C-1:0] we  = '0;
    logic [LA-1:0] line_a  [C];
    logic [WI-1:0] word_a  [C];
    logic [WW-1:0] wdata_a [C];
    logic [C*LA-1:0] core_line;
    logic [C*WI-1:0] core_word;
    logic [C*WW-1:0] core_wdata;
    logic [C-1:0]    core_done;
    logic [C*WW-1:0] core_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < C; g++) begin : g_pack
        assign core_line[g*LA +: LA]  = line_a[g];
        assign core_word[g*WI +: WI]  = word_a[g];
        assign core_wdata[g*WW +: WW] = wdata_a[g];
    end

    shared_line_bus uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_req   (req),
        .core_we    (we),
        .core_line  (core_line),
        .core_word  (core_word),
        .core_wdata (core_wdata),
        .core_done  (core_done),
        .core_rdata (core_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] rd(input int c);
        return core_rdata[c*WW +: WW];
    endfunction

    task automatic set_op(input int c, input bit w, input int ln, input int wd, input logic [31:0] d);
        we[c]      = w;
        line_a[c]  = LA'(ln);
        word_a[c]  = WI'(wd);
        wdata_a[c] = d;
        req[c]     = 1'b1;
    endtask

    // one request from one core; checks latency and (for loads) data
    task automatic single(input int c, input bit w, input int ln, input int wd,
                          input logic [31:0] d, input int exp_lat,
                          input logic [31:0] exp_data, input string tag);
        int lat = -1;
        logic [31:0] got = '0;
        @(posedge clk); #2;
        set_op(c, w, ln, wd, d);
        for (int k = 0; k < 20; k++) begin
            #2;
            if (core_done[c]) begin lat = k; got = rd(c); break; end
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
        req[c] = 1'b0;
        chk(lat == exp_lat, {tag, " latency"}, 32'(lat), 32'(exp_lat));
        if (!w) chk(got == exp_data, {tag, " data"}, got, exp_data);
    endtask

    task automatic t_reset_r1();
        @(posedge clk); #4;
        chk(core_done == '0, "R1 idle done", 32'(core_done), 32'h0);
    endtask

    // all cores miss together: served 0..7, one per cycle (R7, R8, R2, R1)
    task automatic t_round_robin_r7();
        logic [C-1:0] dv;
        @(posedge clk); #2;
        for (int c = 0; c < C; c++) set_op(c, 1'b0, c, c, 32'h0);
        for (int k = 0; k < 9; k++) begin
            #2;
            dv = core_done;
            chk(dv == ((k >= 1) ? C'(1) << (k-1) : '0), "R7/R8 service order",
                32'(dv), 32'((k >= 1) ? (1 << (k-1)) : 0));
            for (int c = 0; c < C; c++)
                if (dv[c]) chk(rd(c) == 32'h0, "R1 bank reads zero", rd(c), 32'h0);
            @(posedge clk); #2;
            req = req & ~dv;
        end
        req = '0;
    endtask

    task automatic t_store_r4();
        single(2, 1'b1, 10, 3, 32'hA5A5_0001, 0, 32'h0, "R4 store");
        single(5, 1'b0, 10, 3, 32'h0, 1, 32'hA5A5_0001, "R4/R2 load after store");
        single(5, 1'b0, 10, 3, 32'h0, 0, 32'hA5A5_0001, "R3 hit after fill");
    endtask

    task automatic t_own_update_r5();
        single(2, 1'b0, 2, 2, 32'h0, 0, 32'h0, "R3 hit on held line");
        single(2, 1'b1, 2, 4, 32'hBEEF_0002, 0, 32'h0, "R5 own store");
        single(2, 1'b0, 2, 4, 32'h0, 0, 32'hBEEF_0002, "R5 own buffer updated");
    endtask

    task automatic t_invalidate_r6();
        single(3, 1'b0, 3, 1, 32'h0, 0, 32'h0, "R6 hit before store");
        single(4, 1'b1, 3, 1, 32'hC0DE_0003, 0, 32'h0, "R6 remote store");
        single(3, 1'b0, 3, 1, 32'h0, 1, 32'hC0DE_0003, "R6 invalidated copy misses");
    endtask

    task automatic t_word_enable_r11();
        single(5, 1'b0, 10, 2, 32'h0, 0, 32'h0, "R11 other word untouched");
        single(5, 1'b0, 10, 3, 32'h0, 0, 32'hA5A5_0001, "R11 written word");
    endtask

    task automatic t_block_r9();
        int lat = -1;
        logic [31:0] got = '0;
        @(posedge clk); #2;
        set_op(6, 1'b0, 6, 0, 32'h0);
        set_op(7, 1'b1, 6, 0, 32'hD00D_0004);
        #2;
        chk(core_done[6] == 1'b0, "R9 hit withheld", 32'(core_done[6]), 32'h0);
        chk(core_done[7] == 1'b1, "R9 store proceeds", 32'(core_done[7]), 32'h1);
        @(posedge clk); #2;
        req[7] = 1'b0;
        for (int k = 1; k < 20; k++) begin
            #2;
            if (core_done[6]) begin lat = k; got = rd(6); break; end
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
        req[6] = 1'b0;
        chk(lat == 2, "R9 retried load latency", 32'(lat), 32'h2);
        chk(got == 32'hD00D_0004, "R9 retried load data", got, 32'hD00D_0004);
    endtask

    task automatic t_merge_r10();
        @(posedge clk); #2;
        set_op(0, 1'b0, 20, 5, 32'h0);
        #2;
        chk(core_done[0] == 1'b0, "R10 miss pending", 32'(core_done[0]), 32'h0);
        @(posedge clk); #2;
        set_op(1, 1'b1, 20, 5, 32'hE1E1_0005);
        #2;
        chk(core_done[0] == 1'b1, "R10 fill returns", 32'(core_done[0]), 32'h1);
        chk(rd(0) == 32'h0, "R10 fill data ordered before store", rd(0), 32'h0);
        chk(core_done[1] == 1'b1, "R10 store during fill", 32'(core_done[1]), 32'h1);
        @(posedge clk); #2;
        req[0] = 1'b0;
        req[1] = 1'b0;
        single(0, 1'b0, 20, 5, 32'h0, 0, 32'hE1E1_0005, "R10 merged buffer");
    endtask

    initial begin
        for (int c = 0; c < C; c++) begin
            line_a[c] = '0; word_a[c] = '0; wdata_a[c] = '0;
        end
        repeat (3) @(posedge clk);
        #2;
        chk(core_done == '0, "R1 done in reset", 32'(core_done), 32'h0);
        rst_n = 1'b1;
        t_reset_r1();
        t_round_robin_r7();
        t_store_r4();
        t_own_update_r5();
        t_invalidate_r6();
        t_word_enable_r11();
        t_block_r9();
        t_merge_r10();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule